// File: doc/BRIEF.md
# SPI Serial Flash Command Sequencer

This block is the slave-side front end of an SPI serial memory. It sees the chip-select, serial clock, serial data in and pause pins as inputs that are already synchronous to the block clock `clk`. It finds the SCK edges by oversampling and supports both SPI mode 0 (SCK idles low) and mode 3 (SCK idles high). It captures SI on rising SCK and changes SO on falling SCK, MSB first. SO is modelled as a data bit plus an output-enable, so that a pad cell can make the tri-state.

After chip-select falls, the block gathers an 8-bit opcode. It then collects a 3-byte address and any dummy bytes, and takes one of three paths. It streams bytes from a synchronous array read port. It streams the status byte or a fixed identification sequence. Or it collects the bytes for a write-type command and hands them to the write-control unit. Program data bytes go out as one-cycle strobes as they arrive. The command itself is requested at the chip-select rising edge and is held until acknowledged. The array, the program and erase timing, and the protection checks all sit outside this block.

The state machine has these states:

- IDLE: deselected.
- OPCODE: the first byte is being received.
- ADDR: address bytes are being received.
- DUMMY: dummy bytes are being received.
- STREAM: read or identification data is being shifted out.
- STATUS: the status byte is being shifted out, repeatedly.
- WDATA: program or status-write data is being received.
- DONE: the command is complete and awaits chip-select high.
- LOCK: the command was refused and the bus is ignored.

Transitions:

- IDLE goes to OPCODE on the CE fall. A CE rise from any state goes to IDLE.
- OPCODE goes to:
  - DONE for 06h, 04h or C7h;
  - STATUS for 05h;
  - WDATA for 01h;
  - ADDR for 03h, 0Bh, 02h, D7h or D8h;
  - DUMMY for ABh;
  - LOCK for any other byte, or for any byte except 05h while busy.
- ADDR goes, after its third byte, to:
  - STREAM for 03h;
  - DUMMY for 0Bh;
  - WDATA for 02h;
  - DONE for D7h or D8h.
- DUMMY goes to STREAM after one byte for 0Bh, or after three bytes for ABh.
- WDATA goes to DONE after one byte for 01h.

Top module: `spi_flash_seq`

## Requirements
- R1: After reset, and from the clock after any chip-select rising edge, `so_oe` is 0, the state is IDLE, and no `mem_rd`, `pg_valid` or new `op_req` is produced by SCK activity.
- R2: SI is sampled on rising SCK edges and SO changes only on falling SCK edges, MSB first, in both mode 0 and mode 3.
- R3: Opcode 03h followed by three address bytes streams array bytes starting at that address, and the address increments after each byte.
- R4: Opcode 0Bh takes three address bytes and one dummy byte, then streams array bytes in the same way as R3.
- R5: Address bits above `ADDR_W` in the 24 received bits are ignored, and streaming reads wrap from address 2^ADDR_W-1 to address 0.
- R6: Opcode ABh takes three dummy bytes and then returns 9Dh, the device code (`DEV_ID`, default 7Ch) and 7Fh, and repeats these three bytes for as long as clocking continues.
- R7: Opcode 05h returns `status_in`, sampled afresh at the start of every byte, for as long as clocking continues within one chip-select period.
- R8: An opcode outside the eleven listed in the state transitions moves the block to LOCK. In LOCK, SO stays undriven, SI is ignored, and no request is made until the next chip-select falling edge.
- R9: When `status_in[0]` (busy) is 1 as an opcode completes, every opcode other than 05h is refused as in R8.
- R10: A write-type command raises `op_req` on the chip-select rising edge with `op_kind` set as follows: 1 for 06h, 2 for 04h, 3 for 01h, 4 for 02h, 5 for D7h, 6 for D8h, 7 for C7h. The request also carries `op_addr` (the start address) and `op_data` (the status byte for 01h). These values are held stable until `op_ack`.
- R11: During 02h, every completed data byte pulses `pg_valid` with `pg_data` and `pg_addr`. The low 8 address bits increment and wrap within the 256-byte page. The program request is raised only if chip-select rises on a byte boundary after at least one data byte.
- R12: Driving `hold_n` low while SCK is low pauses the transfer: `so_oe` goes low and SCK edges and SI are ignored. Raising `hold_n` while SCK is low resumes the transfer with no loss of state.
- R13: A chip-select rising edge in the middle of a byte abandons the command with no request, and the next command is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Transfer pause, active low |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out enable (0 = high impedance) |
| mem_rd | output | 1 | Array read strobe |
| mem_addr | output | ADDR_W | Array read address |
| mem_rdata | input | 8 | Array read data, valid the cycle after `mem_rd` |
| status_in | input | 8 | Status byte from write control; bit 0 = busy |
| pg_valid | output | 1 | Program data byte strobe |
| pg_addr | output | ADDR_W | Address of the program data byte |
| pg_data | output | 8 | Program data byte |
| op_req | output | 1 | Write-type command request, held until `op_ack` |
| op_kind | output | 3 | Command code of the request (see R10) |
| op_addr | output | ADDR_W | Start address of the request |
| op_data | output | 8 | Status-write data byte |
| op_ack | input | 1 | Acknowledge from write control |

## Verification
The bench goes after three groups of corner cases.

- Read wrap and page wrap. A fast read that starts two bytes below the top of the array, with the unused upper address bits set, must wrap to zero. A design that kept the upper bits, or failed to wrap, returns the wrong third byte. A program that starts at the last byte of a page must put its second byte at the page base. A design that carried into the upper address bits, or ran into the next page, reports the wrong `pg_addr`.
- Refused commands. The bench checks an invalid opcode, every command other than status read while busy, and a chip-select rise in the middle of a byte or of a program data byte. A design that decoded too permissively, or committed on an unfinished byte, drives SO or raises a request where none may appear.
- Pause and status. The bench pauses a read with `hold_n` and toggles SCK during the pause, then checks that the next bytes continue in order. It also changes the status between repeated status bytes. A design that counted the paused edges, or latched the status once, returns shifted or stale bytes.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_STREAM,
        ST_STATUS,
        ST_WDATA,
        ST_DONE,
        ST_LOCK
    } fseq_state_e;

    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_WRDI  = 8'h04;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_WRSR  = 8'h01;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_FREAD = 8'h0B;
    localparam logic [7:0] OPC_PROG  = 8'h02;
    localparam logic [7:0] OPC_SERA  = 8'hD7;
    localparam logic [7:0] OPC_BERA  = 8'hD8;
    localparam logic [7:0] OPC_CERA  = 8'hC7;
    localparam logic [7:0] OPC_IDENT = 8'hAB;

    localparam logic [2:0] WOP_NONE = 3'd0;
    localparam logic [2:0] WOP_WEN  = 3'd1;
    localparam logic [2:0] WOP_WDIS = 3'd2;
    localparam logic [2:0] WOP_STW  = 3'd3;
    localparam logic [2:0] WOP_PROG = 3'd4;
    localparam logic [2:0] WOP_SER  = 3'd5;
    localparam logic [2:0] WOP_BER  = 3'd6;
    localparam logic [2:0] WOP_CER  = 3'd7;

endpackage

// File: rtl/fseq_pin_front.sv
module fseq_pin_front (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic held
);
    logic cs_q;
    logic sck_q;
    logic live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
            held  <= 1'b0;
        end else begin
            cs_q  <= cs_n;
            sck_q <= sck;
            if (cs_n) begin
                held <= 1'b0;
            end else if (held) begin
                if (hold_n && !sck) held <= 1'b0;
            end else if (!hold_n && !sck) begin
                held <= 1'b1;
            end
        end
    end

    assign cs_fall  = cs_q && !cs_n;
    assign cs_rise  = !cs_q && cs_n;
    assign live     = !cs_n && !cs_q && !held;
    assign sck_rise = live && sck && !sck_q;
    assign sck_fall = live && !sck && sck_q;

endmodule

// File: rtl/fseq_out_shift.sv
module fseq_out_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       enable,
    input  logic       sck_fall,
    input  logic       held,
    input  logic [7:0] byte_in,
    output logic       so,
    output logic       so_oe,
    output logic       load
);
    logic [2:0] ocnt;
    logic [6:0] rest;
    logic       drive;

    assign load  = enable && sck_fall && (ocnt == 3'd0);
    assign so_oe = drive && !held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ocnt  <= 3'd0;
            rest  <= 7'd0;
            drive <= 1'b0;
            so    <= 1'b0;
        end else if (clear) begin
            ocnt  <= 3'd0;
            drive <= 1'b0;
            so    <= 1'b0;
        end else if (enable && sck_fall) begin
            drive <= 1'b1;
            ocnt  <= 3'(ocnt + 3'd1);
            if (ocnt == 3'd0) begin
                so   <= byte_in[7];
                rest <= byte_in[6:0];
            end else begin
                so   <= rest[6];
                rest <= {rest[5:0], 1'b0};
            end
        end
    end

    // R2
    so_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (so != $past(so)) |-> $past(sck_fall || clear));

endmodule

// File: rtl/fseq_req_port.sv
module fseq_req_port #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [2:0]        kind_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [7:0]        data_in,
    input  logic              op_ack,
    output logic              op_req,
    output logic [2:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_req  <= 1'b0;
            op_kind <= 3'd0;
            op_addr <= '0;
            op_data <= 8'd0;
        end else if (op_req) begin
            if (op_ack) op_req <= 1'b0;
        end else if (commit) begin
            op_req  <= 1'b1;
            op_kind <= kind_in;
            op_addr <= addr_in;
            op_data <= data_in;
        end
    end

    // R10
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && !op_ack) |=> (op_req && $stable(op_kind) && $stable(op_addr) && $stable(op_data)));

endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
    import fseq_pkg::*;
#(
    parameter int         ADDR_W  = 17,
    parameter int         PAGE_W  = 8,
    parameter logic [7:0] MFR_ID  = 8'h9D,
    parameter logic [7:0] DEV_ID  = 8'h7C,
    parameter logic [7:0] MFR_ID2 = 8'h7F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    input  logic [7:0]        status_in,
    output logic              pg_valid,
    output logic [ADDR_W-1:0] pg_addr,
    output logic [7:0]        pg_data,
    output logic              op_req,
    output logic [2:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    input  logic              op_ack
);
    localparam int ADDR_BYTES = 3;
    localparam int ID_BYTES   = 3;

    fseq_state_e state, state_n;

    logic cs_fall, cs_rise, sck_rise, sck_fall, held, load;
    logic [2:0]        bitcnt;
    logic [1:0]        bytecnt;
    logic [6:0]        shin;
    logic [7:0]        byte_now;
    logic              byte_done;
    logic [7:0]        opcode_q;
    logic [ADDR_W-1:0] addr_q, addr_full, prog_start;
    logic [7:0]        wdata_q, rd_buf, out_byte;
    logic              rd_pend, got_byte;
    logic [1:0]        id_idx;
    logic              commit;
    logic [2:0]        kind;
    logic              shift_en;

    fseq_pin_front u_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .held(held)
    );

    assign byte_now  = {shin, si};
    assign byte_done = sck_rise && (bitcnt == 3'd7);
    assign addr_full = ADDR_W'({addr_q, byte_now});
    assign shift_en  = (state == ST_STREAM) || (state == ST_STATUS);

    // next state
    always_comb begin
        state_n = state;
        if (cs_rise) begin
            state_n = ST_IDLE;
        end else if (cs_fall) begin
            state_n = ST_OPCODE;
        end else if (byte_done) begin
            unique case (state)
                ST_OPCODE: begin
                    if (status_in[0] && byte_now != OPC_RDSR) begin
                        state_n = ST_LOCK;
                    end else begin
                        case (byte_now)
                            OPC_WREN, OPC_WRDI, OPC_CERA: state_n = ST_DONE;
                            OPC_RDSR:                     state_n = ST_STATUS;
                            OPC_WRSR:                     state_n = ST_WDATA;
                            OPC_READ, OPC_FREAD, OPC_PROG,
                            OPC_SERA, OPC_BERA:           state_n = ST_ADDR;
                            OPC_IDENT:                    state_n = ST_DUMMY;
                            default:                      state_n = ST_LOCK;
                        endcase
                    end
                end
                ST_ADDR: begin
                    if (bytecnt == 2'(ADDR_BYTES - 1)) begin
                        case (opcode_q)
                            OPC_READ:  state_n = ST_STREAM;
                            OPC_FREAD: state_n = ST_DUMMY;
                            OPC_PROG:  state_n = ST_WDATA;
                            default:   state_n = ST_DONE;
                        endcase
                    end
                end
                ST_DUMMY: begin
                    if (opcode_q != OPC_IDENT || bytecnt == 2'(ID_BYTES - 1))
                        state_n = ST_STREAM;
                end
                ST_WDATA: begin
                    if (opcode_q == OPC_WRSR) state_n = ST_DONE;
                end
                ST_IDLE, ST_STREAM, ST_STATUS, ST_DONE, ST_LOCK: state_n = state;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt     <= 3'd0;
            bytecnt    <= 2'd0;
            shin       <= 7'd0;
            opcode_q   <= 8'd0;
            addr_q     <= '0;
            prog_start <= '0;
            wdata_q    <= 8'd0;
            rd_buf     <= 8'd0;
            rd_pend    <= 1'b0;
            got_byte   <= 1'b0;
            id_idx     <= 2'd0;
            mem_rd     <= 1'b0;
            pg_valid   <= 1'b0;
            pg_addr    <= '0;
            pg_data    <= 8'd0;
        end else begin
            mem_rd   <= 1'b0;
            pg_valid <= 1'b0;
            rd_pend  <= mem_rd;
            if (rd_pend) rd_buf <= mem_rdata;
            if (cs_fall) begin
                bitcnt   <= 3'd0;
                bytecnt  <= 2'd0;
                id_idx   <= 2'd0;
                got_byte <= 1'b0;
            end else if (sck_rise) begin
                bitcnt <= 3'(bitcnt + 3'd1);
                shin   <= {shin[5:0], si};
                if (byte_done) begin
                    bytecnt <= (state_n != state) ? 2'd0 : 2'(bytecnt + 2'd1);
                    if (state == ST_OPCODE) begin
                        opcode_q <= byte_now;
                    end else if (state == ST_ADDR) begin
                        addr_q     <= addr_full;
                        prog_start <= addr_full;
                        if (state_n == ST_STREAM) mem_rd <= 1'b1;
                    end else if (state == ST_DUMMY) begin
                        if (state_n == ST_STREAM && opcode_q != OPC_IDENT) mem_rd <= 1'b1;
                    end else if (state == ST_WDATA) begin
                        if (opcode_q == OPC_WRSR) begin
                            wdata_q <= byte_now;
                        end else begin
                            pg_valid <= 1'b1;
                            pg_addr  <= addr_q;
                            pg_data  <= byte_now;
                            addr_q[PAGE_W-1:0] <= PAGE_W'(addr_q[PAGE_W-1:0] + 1'b1);
                            got_byte <= 1'b1;
                        end
                    end
                end
            end else if (load && state == ST_STREAM) begin
                if (opcode_q == OPC_IDENT) begin
                    id_idx <= (id_idx == 2'(ID_BYTES - 1)) ? 2'd0 : 2'(id_idx + 2'd1);
                end else begin
                    addr_q <= ADDR_W'(addr_q + 1'b1);
                    mem_rd <= 1'b1;
                end
            end
        end
    end

    assign mem_addr = addr_q;

    // output byte source
    always_comb begin
        if (state == ST_STATUS) begin
            out_byte = status_in;
        end else if (opcode_q == OPC_IDENT) begin
            case (id_idx)
                2'd0:    out_byte = MFR_ID;
                2'd1:    out_byte = DEV_ID;
                default: out_byte = MFR_ID2;
            endcase
        end else begin
            out_byte = rd_buf;
        end
    end

    fseq_out_shift u_out (
        .clk(clk), .rst_n(rst_n), .clear(cs_n), .enable(shift_en),
        .sck_fall(sck_fall), .held(held), .byte_in(out_byte),
        .so(so), .so_oe(so_oe), .load(load)
    );

    // request commit
    always_comb begin
        case (opcode_q)
            OPC_WREN: kind = WOP_WEN;
            OPC_WRDI: kind = WOP_WDIS;
            OPC_WRSR: kind = WOP_STW;
            OPC_PROG: kind = WOP_PROG;
            OPC_SERA: kind = WOP_SER;
            OPC_BERA: kind = WOP_BER;
            OPC_CERA: kind = WOP_CER;
            default:  kind = WOP_NONE;
        endcase
    end

    assign commit = cs_rise && (kind != WOP_NONE) &&
                    ((state == ST_DONE) ||
                     (state == ST_WDATA && opcode_q == OPC_PROG && got_byte && bitcnt == 3'd0));

    fseq_req_port #(.ADDR_W(ADDR_W)) u_req (
        .clk(clk), .rst_n(rst_n), .commit(commit), .kind_in(kind),
        .addr_in(opcode_q == OPC_PROG ? prog_start : addr_q), .data_in(wdata_q),
        .op_ack(op_ack), .op_req(op_req), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data)
    );

    // R1
    ce_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (state == ST_IDLE && !so_oe));

    // R8
    lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK) |-> (!so_oe && !pg_valid && !mem_rd));

    // R9
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && state == ST_OPCODE && status_in[0] && byte_now != OPC_RDSR && !cs_rise)
        |=> (state == ST_LOCK));

    // R11
    pg_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_valid |-> $past(sck_rise));

    // R12
    hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !so_oe);

endmodule

// File: tb/tb_spi_flash_seq.sv
module tb_spi_flash_seq;
    localparam int AW = 17;
    localparam int H  = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe, mem_rd, pg_valid, op_req, op_ack = 1'b0;
    logic [AW-1:0] mem_addr, pg_addr, op_addr;
    logic [7:0] mem_rdata = 8'd0, status_in = 8'd0, pg_data, op_data;
    logic [2:0] op_kind;

    spi_flash_seq #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .status_in(status_in), .pg_valid(pg_valid),
        .pg_addr(pg_addr), .pg_data(pg_data), .op_req(op_req), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .op_ack(op_ack)
    );

    function automatic logic [7:0] memv(input logic [AW-1:0] a);
        return a[7:0] ^ a[AW-1:AW-8];
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= memv(mem_addr);

    typedef struct {
        logic [2:0]    kind;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        bit            ca;
        bit            cd;
    } op_t;

    int n_tests = 0, n_fail = 0, n_ops = 0;
    bit mode3 = 1'b0;
    logic [7:0] exp_q[$];
    op_t        exp_ops[$];
    logic [AW+7:0] exp_pg[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        sck = mode3;
        tick(H);
        cs_n = 1'b0;
        tick(H);
    endtask

    task automatic desel();
        tick(H);
        cs_n = 1'b1;
        tick(H);
    endtask

    task automatic xbit(input logic b, output logic r, output logic d);
        if (mode3) begin
            sck = 1'b0; si = b; tick(H);
            r = so; d = so_oe; sck = 1'b1; tick(H);
        end else begin
            si = b; tick(H);
            r = so; d = so_oe; sck = 1'b1; tick(H); sck = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output bit alld, output bit anyd);
        logic r, d;
        alld = 1'b1; anyd = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            xbit(tx[i], r, d);
            rx[i] = r;
            alld &= d;
            anyd |= d;
        end
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] rx; bit a, n;
        xbyte(b, rx, a, n);
    endtask

    task automatic read_cmp(input string tag);
        logic [7:0] rx, e; bit a, n;
        xbyte(8'h00, rx, a, n);
        e = exp_q.pop_front();
        chk(a && rx == e, tag, {23'd0, a, rx}, {24'd1, e});
    endtask

    // scoreboard monitor for requests and program bytes
    always @(negedge clk) begin
        if (op_ack) begin
            op_ack = 1'b0;
        end else if (op_req) begin
            n_ops++;
            if (exp_ops.size() == 0) begin
                chk(1'b0, "R10 unexpected request", {29'd0, op_kind}, 32'd0);
            end else begin
                op_t e;
                e = exp_ops.pop_front();
                chk(op_kind == e.kind && (!e.ca || op_addr == e.addr) && (!e.cd || op_data == e.data),
                    "R10 request contents", {op_kind, op_addr, op_data}, {e.kind, e.addr, e.data});
            end
            op_ack = 1'b1;
        end
        if (pg_valid) begin
            if (exp_pg.size() == 0) begin
                chk(1'b0, "R11 unexpected program byte", {7'd0, pg_addr, pg_data}, 32'd0);
            end else begin
                logic [AW+7:0] e;
                e = exp_pg.pop_front();
                chk({pg_addr, pg_data} == e, "R11 program byte", {7'd0, pg_addr, pg_data}, {7'd0, e});
            end
        end
    end

    task automatic push_op(input logic [2:0] k, input logic [AW-1:0] a, input logic [7:0] d,
                           input bit ca, input bit cd);
        op_t o;
        o.kind = k; o.addr = a; o.data = d; o.ca = ca; o.cd = cd;
        exp_ops.push_back(o);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int ops0;
        logic [7:0] rx; bit a, n, anyd;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1 reset state
        chk(!so_oe && !op_req && !mem_rd && !pg_valid, "R1 reset outputs",
            {so_oe, op_req, mem_rd, pg_valid}, 32'd0);

        // R3 R2 read in mode 0
        mode3 = 1'b0;
        for (int i = 0; i < 3; i++) exp_q.push_back(memv(AW'(17'h00123 + i)));
        sel(); send(8'h03); send(8'h00); send(8'h01); send(8'h23);
        for (int i = 0; i < 3; i++) read_cmp("R3 read stream mode0");
        desel();
        chk(!so_oe, "R1 so released after CE rise", {31'd0, so_oe}, 32'd0);

        // R4 R5 fast read in mode 3 with wrap and ignored upper address bits
        mode3 = 1'b1;
        exp_q.push_back(memv(17'h1FFFE)); exp_q.push_back(memv(17'h1FFFF)); exp_q.push_back(memv(17'h00000));
        sel(); send(8'h0B); send(8'hFF); send(8'hFF); send(8'hFE); send(8'h5A);
        read_cmp("R4 fast read first byte");
        read_cmp("R5 fast read top byte");
        read_cmp("R5 wrap to zero");
        desel();

        // R7 repeated status in mode 3
        status_in = 8'h80;
        sel(); send(8'h05);
        exp_q.push_back(8'h80); read_cmp("R7 status first");
        status_in = 8'h8C;
        exp_q.push_back(8'h8C); read_cmp("R7 status refreshed");
        desel();
        status_in = 8'h00;

        // R8 invalid opcode locks the bus
        mode3 = 1'b0;
        ops0 = n_ops;
        sel(); send(8'h55);
        anyd = 1'b0;
        for (int i = 0; i < 5; i++) begin
            xbyte(i == 0 ? 8'h06 : 8'h03, rx, a, n);
            anyd |= n;
        end
        desel();
        chk(!anyd && n_ops == ops0, "R8 locked after invalid opcode", {30'd0, anyd, 1'b0}, 32'd0);
        exp_q.push_back(memv(17'h00040));
        sel(); send(8'h03); send(8'h00); send(8'h00); send(8'h40);
        read_cmp("R8 next command decoded");
        desel();

        // R9 busy refusal
        status_in = 8'h01;
        sel(); send(8'h03); send(8'h00); send(8'h00); send(8'h00);
        xbyte(8'h00, rx, a, n);
        desel();
        chk(!n, "R9 read refused while busy", {31'd0, n}, 32'd0);
        ops0 = n_ops;
        sel(); send(8'h06); desel();
        chk(n_ops == ops0, "R9 write enable refused while busy", n_ops, ops0);
        status_in = 8'h03;
        sel(); send(8'h05);
        exp_q.push_back(8'h03); read_cmp("R9 status allowed while busy");
        desel();
        status_in = 8'h00;

        // R10 write-type requests
        push_op(3'd1, '0, 8'd0, 1'b0, 1'b0);
        sel(); send(8'h06); desel();
        push_op(3'd2, '0, 8'd0, 1'b0, 1'b0);
        sel(); send(8'h04); desel();
        push_op(3'd3, '0, 8'h8C, 1'b0, 1'b1);
        sel(); send(8'h01); send(8'h8C); desel();
        push_op(3'd5, 17'h12345, 8'd0, 1'b1, 1'b0);
        sel(); send(8'hD7); send(8'h01); send(8'h23); send(8'h45); desel();
        push_op(3'd6, 17'h08000, 8'd0, 1'b1, 1'b0);
        sel(); send(8'hD8); send(8'h00); send(8'h80); send(8'h00); desel();
        push_op(3'd7, '0, 8'd0, 1'b0, 1'b0);
        sel(); send(8'hC7); desel();

        // R11 program with page wrap
        exp_pg.push_back({17'h100FF, 8'hA5});
        exp_pg.push_back({17'h10000, 8'h3C});
        push_op(3'd4, 17'h100FF, 8'd0, 1'b1, 1'b0);
        sel(); send(8'h02); send(8'h01); send(8'h00); send(8'hFF); send(8'hA5); send(8'h3C); desel();

        // R11 R13 program abandoned mid-byte
        ops0 = n_ops;
        exp_pg.push_back({17'h00010, 8'h77});
        sel(); send(8'h02); send(8'h00); send(8'h00); send(8'h10); send(8'h77);
        for (int i = 0; i < 3; i++) begin
            logic r, d;
            xbit(1'b1, r, d);
        end
        desel();
        tick(4);
        chk(n_ops == ops0, "R13 no request on partial byte", n_ops, ops0);

        // R13 CE rise mid-opcode, then R6 identification
        sel();
        for (int i = 0; i < 3; i++) begin
            logic r, d;
            xbit(1'b1, r, d);
        end
        desel();
        exp_q.push_back(8'h9D); exp_q.push_back(8'h7C); exp_q.push_back(8'h7F); exp_q.push_back(8'h9D);
        sel(); send(8'hAB); send(8'h00); send(8'h00); send(8'h00);
        for (int i = 0; i < 4; i++) read_cmp("R6 identification bytes");
        desel();

        // R12 hold pauses a read
        for (int i = 0; i < 3; i++) exp_q.push_back(memv(AW'(17'h00200 + i)));
        sel(); send(8'h03); send(8'h00); send(8'h02); send(8'h00);
        read_cmp("R12 byte before hold");
        hold_n = 1'b0; tick(H);
        chk(!so_oe, "R12 SO floats in hold", {31'd0, so_oe}, 32'd0);
        for (int i = 0; i < 2; i++) begin
            si = 1'b1; sck = 1'b1; tick(H); sck = 1'b0; tick(H);
        end
        chk(!so_oe, "R12 SO floats with SCK toggling", {31'd0, so_oe}, 32'd0);
        hold_n = 1'b1; tick(H);
        chk(so_oe, "R12 SO driven after release", {31'd0, so_oe}, 32'd1);
        read_cmp("R12 byte after hold");
        read_cmp("R12 next byte after hold");
        desel();

        tick(10);
        chk(exp_ops.size() == 0 && exp_pg.size() == 0 && exp_q.size() == 0, "R10 all expected items seen",
            exp_ops.size() + exp_pg.size() + exp_q.size(), 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule